// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short record of finished transmissions for the host. Each time the transmitter reports that a frame is done, the block stores one status entry carrying four flags: interrupt on success requested, jabber, underrun and maximum collisions. The oldest stored entry is always presented on an 8-bit status port. A write strobe on that port discards the entry being shown and exposes the next one.

Completions that reported an error, or that asked for an interrupt on success, produce a one-cycle transmit-complete interrupt pulse. A jabber or underrun completion is fatal. It locks the transmitter, and only the transmit reset input unlocks it. If a completion arrives while the stack is full, its entry is lost and a sticky overflow flag records the loss. Transmit reset also empties the stack and clears the overflow flag.

Top module: `txdone_status_stack`

## Requirements
- R1: A non-empty status byte has this layout: bit 7 = 1 (complete), bit 6 = interrupt on success requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow flag, bits 1:0 = 0.
- R2: When the stack is empty, the status byte is 0x00, whatever the overflow flag holds.
- R3: The stack holds up to 4 entries and shows the oldest one first.
- R4: A cycle with `stat_wr` high and a non-empty stack removes the shown entry. From the next cycle the byte shows the following entry.
- R5: A `stat_wr` strobe while the stack is empty has no effect on the stack or on the outputs.
- R6: An accepted completion that finds the stack full, with no removal in the same cycle, is dropped. It sets the overflow flag, which then shows in bit 2 of every non-empty byte until transmit reset.
- R7: When an accepted completion and a removal happen in the same cycle on a full stack, the completion is stored and no overflow is flagged.
- R8: `txc_irq` is high for exactly the cycle after an accepted completion that has any of jabber, underrun, maximum collisions or interrupt-on-success set. In every other cycle it is low.
- R9: An accepted completion with jabber or underrun sets `tx_locked` from the next cycle. A completion with only maximum collisions does not set it.
- R10: While `tx_locked` is high, completions are ignored: nothing is stored and no interrupt is raised.
- R11: `tx_reset` empties the stack and clears the overflow flag, `tx_locked` and `txc_irq` from the next cycle. It takes priority over a completion or a removal in the same cycle.
- R12: After `rst_n` is asserted, the status byte is 0x00 and `txc_irq` and `tx_locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_valid | input | 1 | One-cycle completion event from the transmitter |
| done_int_req | input | 1 | Completion asked for an interrupt on success |
| done_jabber | input | 1 | Completion ended with jabber |
| done_underrun | input | 1 | Completion ended with underrun |
| done_maxcoll | input | 1 | Completion hit the collision limit |
| stat_wr | input | 1 | Write strobe to the status port; removes the shown entry |
| tx_reset | input | 1 | Synchronous transmit reset |
| stat_byte | output | 8 | Oldest entry, formatted as in R1 |
| txc_irq | output | 1 | Transmit-complete interrupt pulse |
| tx_locked | output | 1 | Transmitter disabled after a fatal completion |

## Verification
The bench aims at the full-stack boundary, where three cases meet:
- A removal paired with a completion must keep the new entry. A design that checks for room before the removal would drop it and raise overflow.
- A lone completion must be dropped. A design that wraps its write pointer would overwrite the oldest entry.
- Writes to an empty stack must not move the counter. A counter that goes below zero would later show stale entries.

It also checks that a locked transmitter ignores completions. A design that gets this wrong stores entries or pulses the interrupt. It also drives transmit reset in the same cycle as a completion. If the completion wins, the stack is left non-empty or the transmitter locked. Finally it checks that a clean completion without an interrupt request stays silent, so that an interrupt raised on every completion is caught.

// File: rtl/txs_pkg.sv
package txs_pkg;

  // Flags kept per stored completion, MSB first as they appear in bits 6..3
  typedef struct packed {
    logic int_req;
    logic jabber;
    logic underrun;
    logic maxcoll;
  } txs_entry_t;

  localparam int ENTRY_W = $bits(txs_entry_t);

  function automatic logic [7:0] txs_format(input logic        valid,
                                            input txs_entry_t  e,
                                            input logic        ovf);
    logic [7:0] b;
    b = valid ? {1'b1, e, ovf, 2'b00} : 8'h00;
    return b;
  endfunction

endpackage

// File: rtl/txs_fifo.sv
module txs_fifo
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  txs_entry_t push_data,
  input  logic       pop,
  output txs_entry_t head,
  output logic       empty,
  output logic       full,
  output logic       drop
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  txs_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pop_eff, push_eff;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);
  assign head  = mem[rd_ptr_q];

  // room is judged after a same-cycle removal
  assign pop_eff  = pop & ~empty & ~flush;
  assign push_eff = push & ~flush & (~full | pop_eff);
  assign drop     = push & ~flush & full & ~pop_eff;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (pop_eff)
        rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      if (push_eff)
        wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      case ({push_eff, pop_eff})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage needs no reset: a slot is only read after it was written
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push_eff && (wr_ptr_q == PTR_W'(i)))
          mem[i] <= push_data;
      end
    end
  endgenerate

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (empty && $stable(rd_ptr_q)));

  p_swap_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop && !flush) |=> full);

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_valid,
  input  txs_entry_t done_flags,
  input  logic       tx_reset,
  input  logic       fifo_drop,
  output logic       accept,
  output logic       ovf_flag,
  output logic       txc_irq,
  output logic       tx_locked
);

  logic fatal, notify;
  logic lock_d, ovf_d, irq_d;
  logic lock_en, ovf_en;

  assign accept = done_valid & ~tx_locked;
  assign fatal  = done_flags.jabber | done_flags.underrun;
  assign notify = done_flags.int_req | done_flags.jabber |
                  done_flags.underrun | done_flags.maxcoll;

  always_comb begin
    lock_en = tx_reset | (accept & fatal);
    lock_d  = ~tx_reset;
    ovf_en  = tx_reset | (accept & fifo_drop);
    ovf_d   = ~tx_reset;
    irq_d   = accept & notify & ~tx_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_locked <= 1'b0;
      ovf_flag  <= 1'b0;
      txc_irq   <= 1'b0;
    end else begin
      if (lock_en) tx_locked <= lock_d;
      if (ovf_en)  ovf_flag  <= ovf_d;
      txc_irq <= irq_d;
    end
  end

  p_lock_fatal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !tx_locked && (done_flags.jabber || done_flags.underrun) && !tx_reset)
      |=> tx_locked);

  p_locked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_locked && !tx_reset) |=> !txc_irq);

  p_ovf_needs_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(fifo_drop));

  p_reset_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!tx_locked && !ovf_flag && !txc_irq));

endmodule

// File: rtl/txdone_status_stack.sv
module txdone_status_stack
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_valid,
  input  logic       done_int_req,
  input  logic       done_jabber,
  input  logic       done_underrun,
  input  logic       done_maxcoll,
  input  logic       stat_wr,
  input  logic       tx_reset,
  output logic [7:0] stat_byte,
  output logic       txc_irq,
  output logic       tx_locked
);

  txs_entry_t flags, head;
  logic       accept, ovf_flag, empty, full, drop;

  assign flags = '{int_req: done_int_req, jabber: done_jabber,
                   underrun: done_underrun, maxcoll: done_maxcoll};

  txs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_valid (done_valid),
    .done_flags (flags),
    .tx_reset   (tx_reset),
    .fifo_drop  (drop),
    .accept     (accept),
    .ovf_flag   (ovf_flag),
    .txc_irq    (txc_irq),
    .tx_locked  (tx_locked)
  );

  txs_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_reset),
    .push      (accept),
    .push_data (flags),
    .pop       (stat_wr),
    .head      (head),
    .empty     (empty),
    .full      (full),
    .drop      (drop)
  );

  assign stat_byte = txs_format(~empty, head, ovf_flag);

  p_empty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (stat_byte == 8'h00));

  p_format_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> (stat_byte[7] && stat_byte[1:0] == 2'b00));

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && full && !stat_wr && !tx_reset) |=> ovf_flag);

endmodule

// File: tb/tb_txdone_status_stack.sv
module tb_txdone_status_stack;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done_valid = 1'b0, done_int_req = 1'b0, done_jabber = 1'b0;
  logic       done_underrun = 1'b0, done_maxcoll = 1'b0;
  logic       stat_wr = 1'b0, tx_reset = 1'b0;
  logic [7:0] stat_byte;
  logic       txc_irq, tx_locked;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R12";

  always #2 clk = ~clk;

  txdone_status_stack dut (
    .clk(clk), .rst_n(rst_n),
    .done_valid(done_valid), .done_int_req(done_int_req),
    .done_jabber(done_jabber), .done_underrun(done_underrun),
    .done_maxcoll(done_maxcoll), .stat_wr(stat_wr), .tx_reset(tx_reset),
    .stat_byte(stat_byte), .txc_irq(txc_irq), .tx_locked(tx_locked)
  );

  // behavioural reference
  logic [3:0] mq[$];
  bit         m_ovf, m_lock, m_irq;

  function automatic logic [7:0] exp_byte();
    if (mq.size() == 0) return 8'h00;
    return {1'b1, mq[0], m_ovf, 2'b00};
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_ovf = 0; m_lock = 0; m_irq = 0;
    end else if (tx_reset) begin
      mq.delete(); m_ovf = 0; m_lock = 0; m_irq = 0;
    end else begin
      bit was_lock;
      was_lock = m_lock;
      if (stat_wr && mq.size() > 0) void'(mq.pop_front());
      m_irq = 0;
      if (done_valid && !was_lock) begin
        m_irq = done_int_req | done_jabber | done_underrun | done_maxcoll;
        if (mq.size() < 4) mq.push_back({done_int_req, done_jabber, done_underrun, done_maxcoll});
        else m_ovf = 1;
        if (done_jabber | done_underrun) m_lock = 1;
      end
    end
    #1;
    chk(cur_req, "stat_byte", stat_byte, exp_byte());
    chk(cur_req, "txc_irq", {7'b0, txc_irq}, {7'b0, m_irq});
    chk(cur_req, "tx_locked", {7'b0, tx_locked}, {7'b0, m_lock});
  end

  // one cycle of stimulus: {int_req,jabber,underrun,maxcoll}
  task automatic step(bit v, logic [3:0] f, bit wr, bit trst);
    @(negedge clk);
    done_valid = v;
    {done_int_req, done_jabber, done_underrun, done_maxcoll} = f;
    stat_wr = wr; tx_reset = trst;
    @(negedge clk);
    done_valid = 0; stat_wr = 0; tx_reset = 0;
    {done_int_req, done_jabber, done_underrun, done_maxcoll} = 4'h0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "reset byte", stat_byte, 8'h00);
    chk("R12", "reset lock", {7'b0, tx_locked}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R8";
    step(1, 4'b1000, 0, 0);          // int_req only
    chk("R1", "first entry", stat_byte, 8'hC0);
    step(1, 4'b0001, 0, 0);          // maxcoll
    cur_req = "R3";
    chk("R3", "oldest shown", stat_byte, 8'hC0);
    step(1, 4'b0000, 0, 0);          // clean, silent
    chk("R8", "clean no irq", {7'b0, txc_irq}, 8'h00);
    step(1, 4'b0000, 0, 0);          // stack now full

    cur_req = "R7";
    step(1, 4'b0001, 1, 0);          // swap on full
    chk("R7", "no ovf on swap", stat_byte, 8'h88);

    cur_req = "R6";
    step(1, 4'b1000, 0, 0);          // dropped
    chk("R6", "ovf bit", stat_byte, 8'h8C);

    cur_req = "R4";
    step(0, 4'h0, 1, 0);
    chk("R4", "after pop", stat_byte, 8'h84);
    step(0, 4'h0, 1, 0);
    step(0, 4'h0, 1, 0);
    chk("R4", "swapped entry kept", stat_byte, 8'h8C);
    step(0, 4'h0, 1, 0);
    chk("R2", "empty zero", stat_byte, 8'h00);

    cur_req = "R5";
    step(0, 4'h0, 1, 0);
    step(0, 4'h0, 1, 0);
    step(1, 4'b1000, 0, 0);
    chk("R5", "no underflow", stat_byte, 8'hC4);

    cur_req = "R11";
    step(0, 4'h0, 0, 1);
    step(1, 4'b1000, 0, 0);
    chk("R11", "ovf cleared", stat_byte, 8'hC0);

    cur_req = "R9";
    step(1, 4'b0001, 0, 0);
    chk("R9", "maxcoll no lock", {7'b0, tx_locked}, 8'h00);
    step(1, 4'b0100, 0, 0);
    chk("R9", "jabber locks", {7'b0, tx_locked}, 8'h01);

    cur_req = "R10";
    step(1, 4'b1000, 0, 0);
    chk("R10", "no irq locked", {7'b0, txc_irq}, 8'h00);
    step(0, 4'h0, 1, 0);
    step(0, 4'h0, 1, 0);
    chk("R10", "third entry jabber", stat_byte, 8'hA0);
    step(0, 4'h0, 1, 0);
    chk("R10", "nothing stored", stat_byte, 8'h00);

    cur_req = "R11";
    step(1, 4'b0010, 0, 1);          // reset beats underrun
    chk("R11", "reset wins lock", {7'b0, tx_locked}, 8'h00);
    chk("R11", "reset wins stack", stat_byte, 8'h00);

    cur_req = "R9";
    step(1, 4'b0010, 0, 0);
    chk("R9", "underrun locks", {7'b0, tx_locked}, 8'h01);
    chk("R1", "underrun byte", stat_byte, 8'h90);

    cur_req = "R3";
    step(0, 4'h0, 0, 1);
    for (int i = 0; i < 4; i++) step(1, 4'(i == 3 ? 4'b1001 : 4'b0000), 0, 0);
    for (int i = 0; i < 3; i++) step(0, 4'h0, 1, 0);
    chk("R3", "fourth slot", stat_byte, 8'hC8);
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule